// File: doc/BRIEF.md
# LIN Slave Operating Mode Controller

This block sets the operating mode of a LIN I/O slave node. It has five modes: configuration, normal, standby (limp home), sleep and limp-home sleep. The block moves between them on single-cycle event strobes from the rest of the node. These strobes are power-on/undervoltage, address assigned, default address first used, two bus-failure timeouts, sleep command, local wake, remote wake and diagnostic response read. LIN framing, PWM and ADC datapaths live elsewhere.

From the mode it drives several outputs: an 8-bit port output register with per-pin output enables, the external-regulator inhibit drive, a mask of enabled slave commands, a one-cycle wake-up signal request toward the master, and a reset for the PWM and ADC units. A configuration bit picks what sleep does to the port register: keep its contents, or load a limp-home value. That choice carries through the wake-up that follows.

Port writes come from decoded data frames. Each write loads the register and arms the output enables of the pins that the direction input marks as outputs.

Top module: `lin_mode_ctrl`

## Requirements
- R1: After reset, or one cycle after a power-on/undervoltage strobe, the block is in configuration mode with the port register at 0, all output enables at 0 and the inhibit driving high. The strobe overrides every other event in the same cycle, including a local wake, so no wake request follows it.
- R2: The command mask (bit 0 = master request, bit 1 = diagnostic response, other bits = remaining commands) is 0001 in configuration, all ones in normal, 0011 in standby and 0 in either sleep mode.
- R3: Configuration mode moves to normal on an address-assigned strobe or a default-address-used strobe.
- R4: In configuration or normal mode, a bus idle timeout or a bus dominant timeout enters standby. A sleep command in configuration mode also enters standby. Entering standby loads the port register with the limp-home value.
- R5: A port write changes the port register and sets each output enable to its direction bit only when the block is in normal mode and stays there. Writes in any other mode leave the port register and the output enables unchanged.
- R6: An address-assigned strobe while in normal mode clears every output enable. The port register is not changed.
- R7: Standby ignores sleep commands and timeouts. It returns to normal only on a diagnostic-read strobe, and the port register keeps its value.
- R8: A sleep command in normal mode with the sleep-select bit at 0 enters sleep. The port register and the output enables hold, and the inhibit output stops driving (0).
- R9: A sleep command in normal mode with the sleep-select bit at 1 enters limp-home sleep. The port register is loaded with the limp-home value and the inhibit output stops driving.
- R10: A local or remote wake in either sleep mode returns to normal with the port register unchanged and the inhibit driving high again. Timeouts and port writes in sleep have no effect.
- R11: A local wake in either sleep mode raises the wake request for exactly one cycle, in the cycle the mode becomes normal. A remote wake alone raises no request.
- R12: The PWM/ADC reset is high exactly while the mode is sleep or limp-home sleep.
- R13: The mode output encodes 0 = configuration, 1 = normal, 2 = standby, 3 = sleep, 4 = limp-home sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_evt | input | 1 | Power-on / undervoltage strobe |
| nad_set | input | 1 | Node address assigned strobe |
| nad_dflt | input | 1 | Default node address first used strobe |
| idle_to | input | 1 | Bus idle timeout strobe |
| dom_to | input | 1 | Bus dominant timeout strobe |
| sleep_cmd | input | 1 | Sleep command received strobe |
| wake_loc | input | 1 | Local wake event strobe |
| wake_rem | input | 1 | Remote wake event strobe |
| diag_rd | input | 1 | Diagnostic response read strobe |
| lslp | input | 1 | Sleep select: 1 loads limp-home values in sleep |
| limp_val | input | NUM_PINS | Limp-home port value |
| port_wr | input | 1 | Port data write strobe |
| port_wdata | input | NUM_PINS | Port data to write |
| port_dir | input | NUM_PINS | Per-pin direction, 1 = output |
| mode | output | 3 | Current mode code |
| port_out | output | NUM_PINS | Port output register |
| port_oe | output | NUM_PINS | Per-pin output enables |
| inh_on | output | 1 | 1 = inhibit drives high, 0 = high impedance |
| cmd_en | output | CMD_W | Enabled command mask |
| wake_req | output | 1 | Wake-up signal request pulse |
| pa_rst | output | 1 | PWM/ADC reset |

## Verification
One stimulus table walks every mode transition with changing limp-home values. Each sleep flavour is entered and then left with a different wake source. This separates holding the port register from loading it, and a local wake pulse from a silent remote wake. Some events arrive in modes that must ignore them: writes in configuration, standby and sleep, a sleep command in standby, and timeouts in sleep. These show that each mode gates its events on its own. Stacked strobes check power-on priority. An address reassignment between writes shows that the enables are cleared while the port data stays.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;

   typedef enum logic [2:0] {
      MODE_CFG   = 3'd0,
      MODE_RUN   = 3'd1,
      MODE_STBY  = 3'd2,
      MODE_SLP   = 3'd3,
      MODE_LHSLP = 3'd4
   } mode_e;

   typedef struct packed {
      logic por;
      logic nad_set;
      logic nad_dflt;
      logic idle_to;
      logic dom_to;
      logic sleep_cmd;
      logic wake_loc;
      logic wake_rem;
      logic diag_rd;
   } evt_t;

   function automatic logic is_sleep(mode_e m);
      return (m == MODE_SLP) || (m == MODE_LHSLP);
   endfunction

endpackage

// File: rtl/lin_mode_fsm.sv
module lin_mode_fsm
   import lin_mode_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  evt_t  ev,
   input  logic  lslp,
   output mode_e mode_q,
   output mode_e mode_d
);

   logic bus_fail;
   assign bus_fail = ev.idle_to | ev.dom_to;

   always_comb begin
      mode_d = mode_q;
      unique case (mode_q)
         MODE_CFG: begin
            if (bus_fail || ev.sleep_cmd)         mode_d = MODE_STBY;
            else if (ev.nad_set || ev.nad_dflt)   mode_d = MODE_RUN;
         end
         MODE_RUN: begin
            if (bus_fail)                         mode_d = MODE_STBY;
            else if (ev.sleep_cmd)                mode_d = lslp ? MODE_LHSLP : MODE_SLP;
         end
         MODE_STBY: begin
            if (ev.diag_rd)                       mode_d = MODE_RUN;
         end
         MODE_SLP, MODE_LHSLP: begin
            if (ev.wake_loc || ev.wake_rem)       mode_d = MODE_RUN;
         end
         default:                                 mode_d = MODE_CFG;
      endcase
      if (ev.por) mode_d = MODE_CFG;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_CFG;
      else        mode_q <= mode_d;
   end

   a_r1_por_to_cfg: assert property (@(posedge clk) disable iff (!rst_n)
      ev.por |=> mode_q == MODE_CFG);

   a_r3_cfg_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_CFG && !ev.por && !bus_fail && !ev.sleep_cmd &&
       (ev.nad_set || ev.nad_dflt)) |=> mode_q == MODE_RUN);

   a_r4_fail_to_stby: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == MODE_CFG || mode_q == MODE_RUN) && !ev.por && bus_fail)
      |=> mode_q == MODE_STBY);

   a_r7_stby_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_STBY && !ev.diag_rd && !ev.por) |=> mode_q == MODE_STBY);

   a_r13_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q inside {MODE_CFG, MODE_RUN, MODE_STBY, MODE_SLP, MODE_LHSLP});

endmodule

// File: rtl/lin_port_bank.sv
module lin_port_bank #(
   parameter int               NUM_PINS = 8,
   parameter logic [NUM_PINS-1:0] PORT_RST = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                por,
   input  logic                load_limp,
   input  logic                wr_en,
   input  logic                oe_clr,
   input  logic [NUM_PINS-1:0] wdata,
   input  logic [NUM_PINS-1:0] dir,
   input  logic [NUM_PINS-1:0] limp,
   output logic [NUM_PINS-1:0] port_q,
   output logic [NUM_PINS-1:0] oe_q
);

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            port_q[i] <= PORT_RST[i];
            oe_q[i]   <= 1'b0;
         end else if (por) begin
            port_q[i] <= PORT_RST[i];
            oe_q[i]   <= 1'b0;
         end else begin
            if (load_limp)   port_q[i] <= limp[i];
            else if (wr_en)  port_q[i] <= wdata[i];
            if (oe_clr)      oe_q[i]   <= 1'b0;
            else if (wr_en)  oe_q[i]   <= dir[i];
         end
      end
   end

   a_r6_oe_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_clr && !por) |=> oe_q == '0);

   a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !por && !load_limp && !oe_clr) |=> port_q == $past(wdata));

endmodule

// File: rtl/lin_mode_out.sv
module lin_mode_out
   import lin_mode_pkg::*;
#(
   parameter int CMD_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  mode_e            mode_q,
   input  logic             por,
   input  logic             wake_loc,
   output logic             inh_on,
   output logic [CMD_W-1:0] cmd_en,
   output logic             wake_req,
   output logic             pa_rst
);

   localparam int BIT_MREQ = 0;
   localparam int BIT_DIAG = 1;

   logic asleep;
   assign asleep = is_sleep(mode_q);
   assign inh_on = !asleep;
   assign pa_rst = asleep;

   for (genvar b = 0; b < CMD_W; b++) begin : g_cmd
      if (b == BIT_MREQ) begin : g_mreq
         assign cmd_en[b] = (mode_q == MODE_CFG) || (mode_q == MODE_RUN) ||
                            (mode_q == MODE_STBY);
      end else if (b == BIT_DIAG) begin : g_diag
         assign cmd_en[b] = (mode_q == MODE_RUN) || (mode_q == MODE_STBY);
      end else begin : g_rest
         assign cmd_en[b] = (mode_q == MODE_RUN);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wake_req <= 1'b0;
      else        wake_req <= asleep && wake_loc && !por;
   end

   a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |=> !wake_req);

   a_r11_wake_after_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> mode_q == MODE_RUN);

   a_r2_sleep_mask: assert property (@(posedge clk) disable iff (!rst_n)
      asleep |-> cmd_en == '0);

endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
   import lin_mode_pkg::*;
#(
   parameter int                  NUM_PINS = 8,
   parameter int                  CMD_W    = 4,
   parameter logic [NUM_PINS-1:0] PORT_RST = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                por_evt,
   input  logic                nad_set,
   input  logic                nad_dflt,
   input  logic                idle_to,
   input  logic                dom_to,
   input  logic                sleep_cmd,
   input  logic                wake_loc,
   input  logic                wake_rem,
   input  logic                diag_rd,
   input  logic                lslp,
   input  logic [NUM_PINS-1:0] limp_val,
   input  logic                port_wr,
   input  logic [NUM_PINS-1:0] port_wdata,
   input  logic [NUM_PINS-1:0] port_dir,
   output logic [2:0]          mode,
   output logic [NUM_PINS-1:0] port_out,
   output logic [NUM_PINS-1:0] port_oe,
   output logic                inh_on,
   output logic [CMD_W-1:0]    cmd_en,
   output logic                wake_req,
   output logic                pa_rst
);

   if (NUM_PINS < 1 || NUM_PINS > 32) begin : g_bad_pins
      $error("lin_mode_ctrl: NUM_PINS must be 1..32");
   end
   if (CMD_W < 2) begin : g_bad_cmd
      $error("lin_mode_ctrl: CMD_W must be at least 2");
   end

   evt_t  ev;
   mode_e mode_q, mode_d;
   logic  load_limp, wr_en, oe_clr, changing;

   assign ev = '{por: por_evt, nad_set: nad_set, nad_dflt: nad_dflt,
                 idle_to: idle_to, dom_to: dom_to, sleep_cmd: sleep_cmd,
                 wake_loc: wake_loc, wake_rem: wake_rem, diag_rd: diag_rd};

   lin_mode_fsm u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev     (ev),
      .lslp   (lslp),
      .mode_q (mode_q),
      .mode_d (mode_d)
   );

   assign changing  = (mode_d != mode_q);
   assign load_limp = changing && !por_evt &&
                      (mode_d == MODE_STBY || mode_d == MODE_LHSLP);
   assign oe_clr    = (mode_q == MODE_RUN) && nad_set;
   assign wr_en     = (mode_q == MODE_RUN) && !changing && port_wr && !nad_set;

   lin_port_bank #(
      .NUM_PINS (NUM_PINS),
      .PORT_RST (PORT_RST)
   ) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .por       (por_evt),
      .load_limp (load_limp),
      .wr_en     (wr_en),
      .oe_clr    (oe_clr),
      .wdata     (port_wdata),
      .dir       (port_dir),
      .limp      (limp_val),
      .port_q    (port_out),
      .oe_q      (port_oe)
   );

   lin_mode_out #(
      .CMD_W (CMD_W)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_q   (mode_q),
      .por      (por_evt),
      .wake_loc (wake_loc),
      .inh_on   (inh_on),
      .cmd_en   (cmd_en),
      .wake_req (wake_req),
      .pa_rst   (pa_rst)
   );

   assign mode = mode_q;

   a_r9_lh_load: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_RUN && sleep_cmd && lslp && !por_evt && !idle_to && !dom_to)
      |=> (mode == 3'd4) && (port_out == $past(limp_val)));

   a_r8_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_RUN && sleep_cmd && !lslp && !por_evt && !idle_to && !dom_to)
      |=> (mode == 3'd3) && $stable(port_out) && $stable(port_oe));

   a_r10_wake_keeps_port: assert property (@(posedge clk) disable iff (!rst_n)
      (is_sleep(mode_q) && !por_evt) |=> $stable(port_out));

   a_r12_reset_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      pa_rst == (mode == 3'd3 || mode == 3'd4));

endmodule

// File: tb/lin_mode_ctrl_bench.sv
`timescale 1ns/1ps
module lin_mode_ctrl_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [8:0] ev = '0;   // {por,nad,dflt,idle,dom,sleep,lwake,rwake,diag}
   logic       lslp = 1'b0;
   logic [7:0] limp = '0;
   logic       wr = 1'b0;
   logic [7:0] wd = '0;
   logic [7:0] dir = 8'h0F;
   logic [2:0] mode;
   logic [7:0] port_out, port_oe;
   logic       inh_on, wake_req, pa_rst;
   logic [3:0] cmd_en;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   lin_mode_ctrl u_lin_mode_ctrl (
      .clk(clk), .rst_n(rst_n),
      .por_evt(ev[8]), .nad_set(ev[7]), .nad_dflt(ev[6]), .idle_to(ev[5]),
      .dom_to(ev[4]), .sleep_cmd(ev[3]), .wake_loc(ev[2]), .wake_rem(ev[1]),
      .diag_rd(ev[0]), .lslp(lslp), .limp_val(limp), .port_wr(wr),
      .port_wdata(wd), .port_dir(dir), .mode(mode), .port_out(port_out),
      .port_oe(port_oe), .inh_on(inh_on), .cmd_en(cmd_en),
      .wake_req(wake_req), .pa_rst(pa_rst)
   );

   typedef struct packed {
      logic [8:0] ev; logic wr; logic [7:0] wd; logic lslp; logic [7:0] limp;
      logic [2:0] m; logic [7:0] p; logic [7:0] oe;
      logic inh; logic wk; logic [3:0] cm; logic pr;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VEC [NV] = '{
      '{9'h000,1'b1,8'h3C,1'b0,8'hA5,3'd0,8'h00,8'h00,1'b1,1'b0,4'h1,1'b0}, // R5 write in cfg
      '{9'h040,1'b0,8'h00,1'b0,8'hA5,3'd1,8'h00,8'h00,1'b1,1'b0,4'hF,1'b0}, // R3 default addr
      '{9'h000,1'b1,8'h3C,1'b0,8'hA5,3'd1,8'h3C,8'h0F,1'b1,1'b0,4'hF,1'b0}, // R5 write
      '{9'h008,1'b0,8'h00,1'b0,8'hA5,3'd3,8'h3C,8'h0F,1'b0,1'b0,4'h0,1'b1}, // R8 sleep
      '{9'h020,1'b1,8'h77,1'b0,8'hA5,3'd3,8'h3C,8'h0F,1'b0,1'b0,4'h0,1'b1}, // R10 ignored
      '{9'h002,1'b0,8'h00,1'b0,8'hA5,3'd1,8'h3C,8'h0F,1'b1,1'b0,4'hF,1'b0}, // R10 remote
      '{9'h008,1'b0,8'h00,1'b1,8'hA5,3'd4,8'hA5,8'h0F,1'b0,1'b0,4'h0,1'b1}, // R9 lh sleep
      '{9'h004,1'b0,8'h00,1'b1,8'h00,3'd1,8'hA5,8'h0F,1'b1,1'b1,4'hF,1'b0}, // R11 local
      '{9'h010,1'b0,8'h00,1'b0,8'h5A,3'd2,8'h5A,8'h0F,1'b1,1'b0,4'h3,1'b0}, // R4 dominant
      '{9'h008,1'b0,8'h00,1'b0,8'h5A,3'd2,8'h5A,8'h0F,1'b1,1'b0,4'h3,1'b0}, // R7 sleep ign
      '{9'h000,1'b1,8'h77,1'b0,8'h5A,3'd2,8'h5A,8'h0F,1'b1,1'b0,4'h3,1'b0}, // R5 stby write
      '{9'h001,1'b0,8'h00,1'b0,8'h5A,3'd1,8'h5A,8'h0F,1'b1,1'b0,4'hF,1'b0}, // R7 diag
      '{9'h080,1'b0,8'h00,1'b0,8'h5A,3'd1,8'h5A,8'h00,1'b1,1'b0,4'hF,1'b0}, // R6 reassign
      '{9'h000,1'b1,8'h11,1'b0,8'h5A,3'd1,8'h11,8'h0F,1'b1,1'b0,4'hF,1'b0}, // R5 rearm
      '{9'h100,1'b0,8'h00,1'b0,8'h5A,3'd0,8'h00,8'h00,1'b1,1'b0,4'h1,1'b0}, // R1 por
      '{9'h008,1'b0,8'h00,1'b0,8'h5A,3'd2,8'h5A,8'h00,1'b1,1'b0,4'h3,1'b0}, // R4 sleep in cfg
      '{9'h001,1'b0,8'h00,1'b0,8'h5A,3'd1,8'h5A,8'h00,1'b1,1'b0,4'hF,1'b0}, // R7 diag
      '{9'h160,1'b0,8'h00,1'b0,8'h5A,3'd0,8'h00,8'h00,1'b1,1'b0,4'h1,1'b0}, // R1 priority
      '{9'h020,1'b0,8'h00,1'b0,8'hC3,3'd2,8'hC3,8'h00,1'b1,1'b0,4'h3,1'b0}  // R4 idle
   };

   function automatic string row_tag(int i);
      case (i)
         0, 2, 10, 13: return "R5";
         1:            return "R3";
         3:            return "R8";
         4, 5:         return "R10";
         6:            return "R9";
         7:            return "R11";
         8, 15, 18:    return "R4";
         9, 11, 16:    return "R7";
         12:           return "R6";
         default:      return "R1";
      endcase
   endfunction

   task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic apply(logic [8:0] e, logic w, logic [7:0] d, logic s, logic [7:0] l);
      @(negedge clk);
      ev = e; wr = w; wd = d; lslp = s; limp = l;
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      @(negedge clk);
      ev = '0; wr = 1'b0;
      @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state, R13 code 0, R2 mask, R12 no reset
      check("R1", "mode", {5'd0, mode}, 8'd0);
      check("R1", "port", port_out, 8'h00);
      check("R1", "oe", port_oe, 8'h00);
      check("R1", "inh", {7'd0, inh_on}, 8'd1);
      check("R2", "mask", {4'd0, cmd_en}, 8'h01);
      check("R12", "pa_rst", {7'd0, pa_rst}, 8'd0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i].ev, VEC[i].wr, VEC[i].wd, VEC[i].lslp, VEC[i].limp);
         check(row_tag(i), "R13 mode", {5'd0, mode}, {5'd0, VEC[i].m});
         check(row_tag(i), "port", port_out, VEC[i].p);
         check(row_tag(i), "oe", port_oe, VEC[i].oe);
         check(row_tag(i), "inh", {7'd0, inh_on}, {7'd0, VEC[i].inh});
         check(row_tag(i), "R11 wake", {7'd0, wake_req}, {7'd0, VEC[i].wk});
         check(row_tag(i), "R2 mask", {4'd0, cmd_en}, {4'd0, VEC[i].cm});
         check(row_tag(i), "R12 pa_rst", {7'd0, pa_rst}, {7'd0, VEC[i].pr});
         idle();
      end

      // R11: pulse lasts one cycle; local+remote together pulses once
      apply(9'h001, 1'b0, 8'h00, 1'b0, 8'h00);
      check("R7", "mode", {5'd0, mode}, 8'd1);
      idle();
      apply(9'h008, 1'b0, 8'h00, 1'b0, 8'h00);
      check("R8", "mode", {5'd0, mode}, 8'd3);
      idle();
      apply(9'h006, 1'b0, 8'h00, 1'b0, 8'h00);
      check("R11", "wake both", {7'd0, wake_req}, 8'd1);
      check("R10", "mode", {5'd0, mode}, 8'd1);
      idle();
      check("R11", "wake width", {7'd0, wake_req}, 8'd0);

      // R1: por with local wake in sleep -> cfg, no pulse
      apply(9'h008, 1'b0, 8'h00, 1'b1, 8'h99);
      check("R9", "port", port_out, 8'h99);
      idle();
      apply(9'h104, 1'b0, 8'h00, 1'b0, 8'h00);
      check("R1", "mode", {5'd0, mode}, 8'd0);
      check("R1", "wake", {7'd0, wake_req}, 8'd0);
      check("R1", "port", port_out, 8'h00);
      idle();

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule